// File: doc/BRIEF.md
# Four-Cell Programmable Logic Tile

This block is a small tile of programmable logic. It holds four logic cells. Each cell is one lookup table with eight inputs and one output, so it can realise any Boolean function of eight variables. A flip-flop captures the table value on every clock edge. A two-way selector then chooses whether the cell drives the combinational table value or the registered value to its tile output.

Every cell input is built by a wired-OR interconnect. Four AND terms each gate one routing-channel signal with a stored control bit, and the four terms are ORed. The routing channel carries the eight tile input pins and the flip-flop outputs of the four cells. Cell feedback therefore always passes through a register, so no configuration can close a combinational loop.

All programming state sits in a single serial shift chain. This state is the table contents, the output-select bits and the crosspoint bits. It is loaded one bit per clock while the load strobe is high. The asynchronous active-low reset is released into the tile through a two-stage synchroniser.

Top module: `tile_fabric`

## Requirements
- R1: While `rst_n` is low, every output is 0 at once, and the configuration and all cell flip-flops are cleared. After release and before any load, every output stays 0 for any pin values.
- R2: Each clock with `cfg_load` high shifts `cfg_bit` into the chain; after 1156 shifts the k-th bit sent (counting from 0) sits at position k. Table of cell c, address a: position 256c+a. Output select of cell c: 1024+c. Crosspoint term t of input i of cell c: 1028+32c+4i+t. With `cfg_load` low the chain holds.
- R3: A cell's table value is its stored bit at address {in7,...,in0}, with in0 as the least significant address bit.
- R4: With its select bit 0, a cell drives its table value to `tile_out` combinationally, in the same cycle as the pin change.
- R5: With its select bit 1, a cell drives its flip-flop. The flip-flop loads the table value at each rising edge while `cfg_load` is low, and holds while `cfg_load` is high.
- R6: Input i of cell c is the OR of the enabled terms. Term 0 is pin i. Term 1 is the flip-flop of cell (i mod 4). Term 2 is pin ((i+4) mod 8). Term 3 is the flip-flop of cell ((i+c+1) mod 4). With no term enabled the input reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, release synchronised |
| cfg_load | input | 1 | Shift-enable of the configuration chain; freezes cell flip-flops |
| cfg_bit | input | 1 | Serial configuration data |
| pin_in | input | 8 | Tile input pins, routing channel positions 0 to 7 |
| tile_out | output | 4 | Selected output of each cell, bit c for cell c |

## Verification
A combinational result of a cell with select 0 follows a pin change within the same cycle. The bench drives pins at the falling edge and samples 1 ns later, before any rising edge. A registered result appears one rising edge after the table value it captures. Those checks sample 1 ns after that edge. The counter model steps once per rising edge with `cfg_load` low and enable high, including the single edge between a pin change and the next load start. During a reload the model is frozen, so the value read back after the load must equal the value read before it.

// File: rtl/tile_pkg.sv
package tile_pkg;
  localparam int NCELL   = 4;
  localparam int NIN     = 8;
  localparam int NTERM   = 4;
  localparam int NPIN    = 8;

  // Candidate routing-channel index for term t of input i of cell c.
  // Channel: [npin-1:0] pins, then one flip-flop output per cell.
  function automatic int src_idx(int npin, int ncell, int c, int i, int t);
    case (t % 4)
      0:       return i % npin;
      1:       return npin + (i % ncell);
      2:       return (i + npin / 2) % npin;
      default: return npin + ((i + c + 1) % ncell);
    endcase
  endfunction
endpackage

// File: rtl/tile_rst_sync.sv
module tile_rst_sync (
  input  logic clk,
  input  logic rst_n_i,
  output logic rst_n_o
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) stage_q <= 2'b00;
    else          stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_n_o = stage_q[1];
endmodule

// File: rtl/tile_cfg_chain.sv
module tile_cfg_chain #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         shift_en,
  input  logic         din,
  output logic [W-1:0] cfg_q
);
  logic [W-1:0] cfg_d;

  always_comb begin
    cfg_d = cfg_q;
    if (shift_en) cfg_d = {din, cfg_q[W-1:1]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg_q <= '0;
    else        cfg_q <= cfg_d;
  end

  // R2: chain keeps its contents when not loading
  p_cfg_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !shift_en |=> cfg_q == $past(cfg_q));
endmodule

// File: rtl/tile_xp_dest.sv
module tile_xp_dest #(
  parameter int NSRC = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] src,
  input  logic [NSRC-1:0] ctrl,
  output logic            dst
);
  logic [NSRC-1:0] term;

  assign term = src & ctrl;
  assign dst  = |term;

  // R6: an input with no enabled crosspoint reads 0
  p_no_ctrl_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl == '0) |-> !dst);
endmodule

// File: rtl/tile_cell.sv
module tile_cell #(
  parameter int NIN = 8,
  localparam int MW = 1 << NIN
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           hold,
  input  logic           sel_reg,
  input  logic [MW-1:0]  mask,
  input  logic [NIN-1:0] ins,
  output logic           q,
  output logic           y
);
  logic lut_val;
  logic q_d;
  logic q_en;

  assign lut_val = mask[ins];
  assign q_en    = !hold;

  always_comb begin
    q_d = q;
    if (q_en) q_d = lut_val;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= 1'b0;
    else        q <= q_d;
  end

  assign y = sel_reg ? q : lut_val;

  // R5: flip-flop frozen while configuration is loading
  p_ff_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> q == $past(q));

  // R5: flip-flop takes the addressed table bit when running
  p_ff_capture_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !hold |=> q == $past(mask[ins]));
endmodule

// File: rtl/tile_fabric.sv
module tile_fabric #(
  parameter int NCELL = tile_pkg::NCELL,
  parameter int NIN   = tile_pkg::NIN,
  parameter int NTERM = tile_pkg::NTERM,
  parameter int NPIN  = tile_pkg::NPIN
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_load,
  input  logic            cfg_bit,
  input  logic [NPIN-1:0] pin_in,
  output logic [NCELL-1:0] tile_out
);
  localparam int MW       = 1 << NIN;
  localparam int SEL_BASE = NCELL * MW;
  localparam int XP_BASE  = SEL_BASE + NCELL;
  localparam int CFG_W    = XP_BASE + NCELL * NIN * NTERM;
  localparam int CHAN_W   = NPIN + NCELL;

  logic              rst_n_s;
  logic [CFG_W-1:0]  cfg;
  logic [NCELL-1:0]  cell_q;
  logic [CHAN_W-1:0] chan;

  tile_rst_sync u_rst (
    .clk     (clk),
    .rst_n_i (rst_n),
    .rst_n_o (rst_n_s)
  );

  tile_cfg_chain #(.W(CFG_W)) u_chain (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .shift_en (cfg_load),
    .din      (cfg_bit),
    .cfg_q    (cfg)
  );

  // Feedback enters the channel only from the flip-flops.
  assign chan = {cell_q, pin_in};

  for (genvar c = 0; c < NCELL; c++) begin : g_cell
    logic [NIN-1:0] ins;

    for (genvar i = 0; i < NIN; i++) begin : g_in
      logic [NTERM-1:0] cand;
      for (genvar t = 0; t < NTERM; t++) begin : g_term
        assign cand[t] = chan[tile_pkg::src_idx(NPIN, NCELL, c, i, t)];
      end

      tile_xp_dest #(.NSRC(NTERM)) u_xp (
        .clk   (clk),
        .rst_n (rst_n_s),
        .src   (cand),
        .ctrl  (cfg[XP_BASE + (c*NIN + i)*NTERM +: NTERM]),
        .dst   (ins[i])
      );
    end

    tile_cell #(.NIN(NIN)) u_cell (
      .clk     (clk),
      .rst_n   (rst_n_s),
      .hold    (cfg_load),
      .sel_reg (cfg[SEL_BASE + c]),
      .mask    (cfg[c*MW +: MW]),
      .ins     (ins),
      .q       (cell_q[c]),
      .y       (tile_out[c])
    );
  end
endmodule

// File: tb/tile_fabric_bench.sv
`timescale 1ns/1ps
module tile_fabric_bench;
  localparam int NCELL = 4, NIN = 8, NTERM = 4, NPIN = 8;
  localparam int MW = 1 << NIN;
  localparam int SEL_BASE = NCELL * MW;
  localparam int XP_BASE = SEL_BASE + NCELL;
  localparam int CFG_W = XP_BASE + NCELL * NIN * NTERM;

  // {pins, expected tile_out}; bits 2:0 combinational, bit 3 registered
  localparam logic [11:0] VEC [8] = '{
    {8'h00, 4'b0001}, {8'hA5, 4'b1100}, {8'h33, 4'b1101}, {8'h10, 4'b0110},
    {8'h01, 4'b1110}, {8'hFF, 4'b1101}, {8'h7E, 4'b0100}, {8'h80, 4'b0010}
  };

  logic clk = 1'b0;
  logic rst_n, cfg_load, cfg_bit;
  logic [NPIN-1:0] pin_in;
  logic [NCELL-1:0] tile_out;
  int n_chk = 0, n_fail = 0;
  logic [CFG_W-1:0] img_a, img_b;
  logic [3:0] model;

  always #2.5 clk = ~clk;

  tile_fabric u_tile_fabric (
    .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .cfg_bit(cfg_bit),
    .pin_in(pin_in), .tile_out(tile_out)
  );

  function automatic int xp(int c, int i, int t);
    return XP_BASE + (c*NIN + i)*NTERM + t;
  endfunction

  task automatic chk(input string req, input logic [3:0] act, input logic [3:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: tile_out=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic load(input logic [CFG_W-1:0] img);
    for (int k = 0; k < CFG_W; k++) begin
      @(negedge clk); cfg_load = 1'b1; cfg_bit = img[k];
    end
    @(negedge clk); cfg_load = 1'b0; cfg_bit = 1'b0;
  endtask

  initial begin
    #(5.0 * 150000);
    n_fail++;
    $display("FAIL watchdog: run did not finish");
    $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    // Image A: equality, parity, OR routing, registered follower
    img_a = '0;
    for (int a = 0; a < MW; a++) begin
      logic [7:0] ad;
      ad = a[7:0];
      img_a[a]        = (ad[3:0] == ad[7:4]);
      img_a[MW + a]   = ^ad;
      img_a[2*MW + a] = ad[0] | ad[1];
      img_a[3*MW + a] = ad[0];
    end
    img_a[SEL_BASE + 3] = 1'b1;
    for (int i = 0; i < NIN; i++) begin
      img_a[xp(0, i, 0)] = 1'b1;
      img_a[xp(1, i, 0)] = 1'b1;
    end
    img_a[xp(2, 0, 0)] = 1'b1;
    img_a[xp(2, 0, 2)] = 1'b1;   // in0 of cell 2 = pin0 | pin4; in1 left open
    img_a[xp(3, 0, 0)] = 1'b1;

    // Image B: 4-bit counter, enable on pin4
    img_b = '0;
    for (int c = 0; c < NCELL; c++) begin
      img_b[SEL_BASE + c] = 1'b1;
      for (int a = 0; a < MW; a++) begin
        logic [7:0] ad;
        logic cy;
        ad = a[7:0];
        cy = ad[4];
        for (int j = 0; j < c; j++) cy = cy & ad[j];
        img_b[c*MW + a] = ad[c] ^ cy;
      end
      for (int i = 0; i < 4; i++)
        img_b[(c == 3 && i == 3) ? xp(c, i, 3) : xp(c, i, 1)] = 1'b1;
      img_b[xp(c, 4, 0)] = 1'b1;
    end

    rst_n = 1'b0; cfg_load = 1'b0; cfg_bit = 1'b0; pin_in = '0;
    repeat (3) @(negedge clk);
    chk("R1 reset", tile_out, 4'b0000);
    pin_in = 8'hFF; #1;
    chk("R1 unconfigured", tile_out, 4'b0000);
    @(negedge clk); rst_n = 1'b1;
    repeat (3) @(negedge clk);

    load(img_a);
    foreach (VEC[v]) begin
      @(negedge clk); pin_in = VEC[v][11:4]; #1;
      chk("R3 R4 R6 combinational cells", {1'b0, tile_out[2:0]}, {1'b0, VEC[v][2:0]});
      @(posedge clk); #1;
      chk("R5 registered cell", {3'b000, tile_out[3]}, {3'b000, VEC[v][3]});
    end

    @(negedge clk); pin_in = 8'h00;
    load(img_b);
    #1 model = tile_out;
    @(negedge clk); pin_in = 8'h10;
    for (int n = 0; n < 20; n++) begin
      @(posedge clk); #1; model = model + 4'd1;
      chk("R3 R6 counter step", tile_out, model);
    end
    @(negedge clk); pin_in = 8'h00;
    for (int n = 0; n < 3; n++) begin
      @(posedge clk); #1;
      chk("R3 counter disabled", tile_out, model);
    end
    @(negedge clk); pin_in = 8'h10;
    load(img_b);
    model = model + 4'd1;     // one edge ran before the load began
    #1 chk("R5 hold during load", tile_out, model);
    @(posedge clk); #1; model = model + 4'd1;
    chk("R5 resume after load", tile_out, model);

    @(negedge clk); rst_n = 1'b0; #1;
    chk("R1 async reset", tile_out, 4'b0000);
    @(negedge clk); rst_n = 1'b1;
    repeat (4) @(posedge clk); #1;
    chk("R1 cleared config", tile_out, 4'b0000);

    $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule